// File: doc/BRIEF.md
# Converter Serial Readout Port

This block is the read side of a data converter's serial interface. A one-cycle completion strobe offers a fresh parallel conversion result. The block keeps that result in a holding register and pulls an active-low ready line low. An external host then selects the port with an active-low select line. It shifts the word out most significant bit first on a data line that can be released to high impedance. The host supplies the serial clock. Release is modelled as a data value plus an output enable.

The chip-select and serial-clock pins are asynchronous to the fast system clock. Each passes through a two-stage synchroniser, and edges are found on the synchronised copies. The serial clock must run at no more than a quarter of the system clock rate.

A controller with five states runs the port:
- `ST_IDLE`: deselected.
- `ST_GRAB`: select is held low while the port waits out the takeover delay.
- `ST_WAIT_WORD`: the port owns the bus but has nothing to send.
- `ST_PRESENT`: the top bit is driven and the shifter is not yet armed.
- `ST_SHIFT`: armed.

The transitions are:
- `ST_IDLE`→`ST_GRAB` when select falls.
- `ST_GRAB`→`ST_PRESENT` or `ST_WAIT_WORD` once the delay count ends.
- `ST_WAIT_WORD`→`ST_PRESENT` when a word is held.
- `ST_PRESENT`→`ST_SHIFT` on a serial clock rising edge.
- `ST_SHIFT`→`ST_WAIT_WORD` on the falling edge that ends the last bit.
- Any state→`ST_IDLE` whenever select is high.

Top module: `cvt_serial_port`

## Requirements
- R1: After reset, `sdo_oe` is low and `rdy_n` is high.
- R2: A `conv_done` strobe loads `conv_word` into the holding register, and `rdy_n` goes low the cycle after the strobe. This happens when the port is deselected or when no word is held (the last one was fully read out).
- R3: While the port is deselected, a newer strobe overwrites a held but unread word, and the newer word is the one read out.
- R4: While the port is selected and a word is still held, a strobe is discarded and the held word and its bit position are kept.
- R5: The port takes the bus only after synchronised select has been low for 2 + `GRAB_MARGIN` system cycles. Serial clock edges before that point have no effect, and `sdo_oe` stays low until then.
- R6: When the port takes the bus with a word held, `sdo_oe` goes high with bit 15 (the MSB) already on `sdo`, without any serial clock edge.
- R7: Only a serial clock rising edge arms the shifter. A falling edge before arming is ignored, including when the clock is already high as the MSB appears.
- R8: Once armed, each falling edge moves `sdo` to the next lower bit, bit 15 first and bit 0 last.
- R9: The falling edge that ends bit 0 drops `sdo_oe` and returns `rdy_n` high.
- R10: Raising select mid-word drops `sdo_oe` while `rdy_n` stays low. The next selection restarts at bit 15 of the same word.
- R11: `sdo_oe` is low whenever the port is not presenting a bit (deselected, waiting out the delay, or holding no word).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: conversion result available |
| conv_word | input | 16 | Conversion result, valid with `conv_done` |
| sel_n | input | 1 | Active-low port select, asynchronous |
| sclk | input | 1 | Serial clock from host, asynchronous |
| sdo | output | 1 | Serial data bit (meaningful when `sdo_oe` is high) |
| sdo_oe | output | 1 | Output enable; low means high impedance |
| rdy_n | output | 1 | Active-low word-ready flag |

## Verification
A wrong state in the controller appears at the enable pin within three system cycles of the serial clock or select edge that caused it. A wrongly armed shifter shows up as a bit skipped or repeated on the next falling edge, because every bit is compared at a settled point between edges. A wrong reload decision shows up later, when the next selection presents the wrong top bit. A mis-set ready flag shows up one cycle after the strobe or after the final falling edge.

// File: rtl/cvt_port_pkg.sv
package cvt_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GRAB,
        ST_WAIT_WORD,
        ST_PRESENT,
        ST_SHIFT
    } port_st_t;

endpackage

// File: rtl/cvt_line_sync.sv
// Multi-stage synchroniser for one asynchronous control pin.
module cvt_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], pin};
        end
    end

    assign lvl = chain[STAGES-1];
endmodule

// File: rtl/cvt_word_hold.sv
// Holding register with reload gating and the ready flag.
module cvt_word_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_done,
    input  logic [W-1:0] conv_word,
    input  logic         sel_s,
    input  logic         take,
    output logic [W-1:0] word,
    output logic         valid
);
    logic load_ok;

    // Reload only when emptied or deselected.
    assign load_ok = conv_done && (!valid || sel_s);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word  <= '0;
            valid <= 1'b0;
        end else if (load_ok) begin
            word  <= conv_word;
            valid <= 1'b1;
        end else if (take) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/cvt_shift_ctrl.sv
// Bus takeover, arming and bit sequencing.
module cvt_shift_ctrl
    import cvt_port_pkg::*;
#(
    parameter int W           = 16,
    parameter int GRAB_MARGIN = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_s,
    input  logic         sclk_s,
    input  logic         word_valid,
    input  logic [W-1:0] word,
    output logic         take,
    output logic         sdo,
    output logic         sdo_oe
);
    localparam int GRAB_CYC = 2 + GRAB_MARGIN;
    localparam int CNT_W    = $clog2(GRAB_CYC + 1);
    localparam int IDX_W    = $clog2(W);

    port_st_t         st, nxt;
    logic [CNT_W-1:0] grab_cnt;
    logic [IDX_W-1:0] bit_idx;
    logic             sclk_prev;
    logic             sclk_rise, sclk_fall, grab_done, last_bit;

    assign sclk_rise = sclk_s && !sclk_prev;
    assign sclk_fall = !sclk_s && sclk_prev;
    assign grab_done = (grab_cnt == CNT_W'(GRAB_CYC - 1));
    assign last_bit  = (bit_idx == '0);

    // Next-state logic.
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:      if (!sel_s) nxt = ST_GRAB;
            ST_GRAB: begin
                if (sel_s)          nxt = ST_IDLE;
                else if (grab_done) nxt = word_valid ? ST_PRESENT : ST_WAIT_WORD;
            end
            ST_WAIT_WORD: begin
                if (sel_s)           nxt = ST_IDLE;
                else if (word_valid) nxt = ST_PRESENT;
            end
            ST_PRESENT: begin
                if (sel_s)          nxt = ST_IDLE;
                else if (sclk_rise) nxt = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (sel_s)                      nxt = ST_IDLE;
                else if (sclk_fall && last_bit) nxt = ST_WAIT_WORD;
            end
            default:      nxt = ST_IDLE;
        endcase
    end

    // State register with its counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            grab_cnt  <= '0;
            bit_idx   <= IDX_W'(W - 1);
            sclk_prev <= 1'b0;
        end else begin
            st        <= nxt;
            sclk_prev <= sclk_s;
            grab_cnt  <= (st == ST_GRAB) ? grab_cnt + 1'b1 : '0;
            if (st != ST_SHIFT) begin
                bit_idx <= IDX_W'(W - 1);
            end else if (sclk_fall) begin
                bit_idx <= bit_idx - 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        sdo_oe = 1'b0;
        take   = 1'b0;
        unique case (st)
            ST_PRESENT: sdo_oe = 1'b1;
            ST_SHIFT: begin
                sdo_oe = 1'b1;
                take   = !sel_s && sclk_fall && last_bit;
            end
            default: ;
        endcase
        sdo = sdo_oe ? word[bit_idx] : 1'b0;
    end
endmodule

// File: rtl/cvt_serial_port.sv
module cvt_serial_port #(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2,
    parameter int GRAB_MARGIN = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_done,
    input  logic [W-1:0] conv_word,
    input  logic         sel_n,
    input  logic         sclk,
    output logic         sdo,
    output logic         sdo_oe,
    output logic         rdy_n
);
    logic         sel_s, sclk_s, take, valid;
    logic [W-1:0] hold_word;

    cvt_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .pin(sel_n), .lvl(sel_s)
    );

    cvt_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .pin(sclk), .lvl(sclk_s)
    );

    cvt_word_hold #(.W(W)) u_hold (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_word(conv_word),
        .sel_s(sel_s), .take(take), .word(hold_word), .valid(valid)
    );

    cvt_shift_ctrl #(.W(W), .GRAB_MARGIN(GRAB_MARGIN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sclk_s(sclk_s),
        .word_valid(valid), .word(hold_word), .take(take),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    assign rdy_n = !valid;
endmodule

// File: rtl/cvt_serial_port_chk.sv
module cvt_serial_port_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         conv_done,
    input logic         sel_s,
    input logic         sdo,
    input logic         sdo_oe,
    input logic         rdy_n,
    input logic [W-1:0] hold_word
);
    p_oe_needs_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> !rdy_n);

    p_rdy_falls_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(conv_done));

    p_desel_tristate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> !sdo_oe);

    p_msb_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> (sdo == hold_word[W-1]));

    p_rdy_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_n) |-> $fell(sdo_oe));

    p_discard_keeps_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !rdy_n && !sel_s) |=> $stable(hold_word));
endmodule

bind cvt_serial_port cvt_serial_port_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .sel_s(sel_s),
    .sdo(sdo), .sdo_oe(sdo_oe), .rdy_n(rdy_n), .hold_word(hold_word)
);

// File: tb/cvt_serial_port_bench.sv
`timescale 1ns/1ps
module cvt_serial_port_bench;
    localparam int W = 16;

    typedef struct {
        logic  oe;
        logic  bitv;
        logic  rdy;
        string req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_done = 1'b0;
    logic [W-1:0] conv_word = '0;
    logic         sel_n = 1'b1;
    logic         sclk = 1'b0;
    logic         sdo, sdo_oe, rdy_n;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];
    event smp;

    always #10 clk = ~clk;

    cvt_serial_port #(.W(W)) u_cvt_serial_port (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_word(conv_word),
        .sel_n(sel_n), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .rdy_n(rdy_n)
    );

    // Monitor: pops expected items and compares with the ports.
    initial begin
        forever begin
            @(smp);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (sdo_oe !== e.oe || rdy_n !== e.rdy || (e.oe && sdo !== e.bitv)) begin
                    n_fail++;
                    $display("FAIL %s: oe/sdo/rdy_n got %b/%b/%b expected %b/%b/%b",
                             e.req, sdo_oe, sdo, rdy_n, e.oe, e.bitv, e.rdy);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic oe, input logic b, input logic rdy, input string req);
        exp_t e;
        e.oe = oe; e.bitv = b; e.rdy = rdy; e.req = req;
        exp_q.push_back(e);
        -> smp;
        #1;
    endtask

    task automatic strobe(input logic [W-1:0] w);
        conv_word = w; conv_done = 1'b1;
        tick(1);
        conv_done = 1'b0;
        tick(3);
    endtask

    // Clocks out n bits starting from the presented MSB (R8, R9).
    task automatic shift_word(input logic [W-1:0] w, input int first, input int nbits);
        for (int k = first; k > first - nbits; k--) begin
            sclk = 1'b1; tick(4);
            sclk = 1'b0; tick(4);
            if (k == 0) expect_out(1'b0, 1'b0, 1'b1, "R9");
            else        expect_out(1'b1, w[k-1], 1'b0, "R8");
        end
    endtask

    localparam logic [W-1:0] WA = 16'hA5C3;
    localparam logic [W-1:0] WB = 16'h6B2D;
    localparam logic [W-1:0] WC = 16'hF00F;
    localparam logic [W-1:0] WD = 16'h3C5A;
    localparam logic [W-1:0] WE = 16'h9E17;

    initial begin
        tick(3);
        expect_out(1'b0, 1'b0, 1'b1, "R1");
        rst_n = 1'b1;
        tick(2);
        expect_out(1'b0, 1'b0, 1'b1, "R1");

        // R2: load while deselected
        strobe(WA);
        expect_out(1'b0, 1'b0, 1'b0, "R2");

        // R5: early serial clock edges during takeover are ignored
        sel_n = 1'b0; sclk = 1'b1;
        tick(2); sclk = 1'b0;
        tick(1);
        expect_out(1'b0, 1'b0, 1'b0, "R5");
        tick(9);
        expect_out(1'b1, WA[15], 1'b0, "R6");
        shift_word(WA, 15, 16);

        // R11 / R2: emptied while selected, fresh word presented
        expect_out(1'b0, 1'b0, 1'b1, "R11");
        strobe(WB);
        expect_out(1'b1, WB[15], 1'b0, "R2");
        shift_word(WB, 15, 3);

        // R4: strobe discarded while selected and word held
        strobe(WC);
        expect_out(1'b1, WB[12], 1'b0, "R4");

        // R10: abort mid-word, restart at MSB
        sel_n = 1'b1; tick(4);
        expect_out(1'b0, 1'b0, 1'b0, "R10");
        sel_n = 1'b0; tick(12);
        expect_out(1'b1, WB[15], 1'b0, "R10");
        shift_word(WB, 15, 16);
        sel_n = 1'b1; tick(4);
        expect_out(1'b0, 1'b0, 1'b1, "R11");

        // R3: overwrite while deselected
        strobe(WD);
        expect_out(1'b0, 1'b0, 1'b0, "R2");
        strobe(WE);

        // R7: clock already high when MSB appears
        sclk = 1'b1; tick(4);
        sel_n = 1'b0; tick(12);
        expect_out(1'b1, WE[15], 1'b0, "R3");
        sclk = 1'b0; tick(4);
        expect_out(1'b1, WE[15], 1'b0, "R7");
        shift_word(WE, 15, 16);
        sel_n = 1'b1; tick(4);
        expect_out(1'b0, 1'b0, 1'b1, "R11");

        tick(2);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run incomplete, expected to finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule